// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block paces the clock line of an I2C master. A byte engine raises `run` to ask for bus clocking. The generator then emits the SCL level and a set of one-cycle strobes: the start point, each SCL falling and rising edge, and the point inside each low phase where SDA may change. Phase lengths come from three nested counts. A clock divider thins the source clock. A sample counter turns divided cycles into sample ticks. A step counter counts sample ticks until the phase ends. The high and low phases carry their own sample and step counts, so an asymmetric duty cycle keeps the period that software chose.

Software computes the timing words for a target bus speed and writes them through a small write port into a shadow set. The generator copies the shadow set into its active set only while it is idle. A configuration change therefore never cuts a phase short or stretches it. Every count field holds its value minus one.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, `scl` is 1, every strobe is 0, the generator is idle and all shadow and active fields are zero.
- R2: Writes select a word by `wrAddr`. Address 0 holds the high sample count in bits [10:8] and the high step count in bits [5:0]. Address 1 holds the low sample count in bits [8:6] and the low step count in bits [5:0]. Address 2 holds the start-setup count in bits [15:8], the divider in bits [3:1] and the setup enable in bit 0. Address 3 holds the SDA change point in bits [5:0].
- R3: With divider field D, sample field S and step field P, a phase lasts (D+1)(S+1)(P+1) source cycles. High phases use the high fields and low phases use the low fields.
- R4: The SCL period equals the sum of the high and low phase lengths, measured between successive `sclFall` strobes.
- R5: With the setup enable at 1, `run` seen in idle starts a setup interval of U+1 source cycles (U is the setup field, at most 256 cycles). `startStb` then pulses for one cycle with `scl` still high, and the first high phase begins.
- R6: With the setup enable at 0, `startStb` pulses in the cycle right after `run` is seen in idle.
- R7: `sclFall` is 1 only in the first cycle of each low phase, and `sclRise` is 1 only in the first cycle of each following high phase. These strobes and `startStb` are never 1 together.
- R8: With SDA change field H, `sdaChg` pulses once per low phase, right after (H+1) sample ticks of that phase. When H equals the low step field, it coincides with `sclRise`. When H is larger, it never pulses.
- R9: A low phase always runs to its end. When `run` is 0 at the end of a high phase, the generator goes idle with `scl` held high and no further strobes.
- R10: Shadow writes made while the generator is active leave the active timing untouched. They take effect from the next idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Timing word write strobe |
| wrAddr | input | 2 | Timing word select |
| wrData | input | 16 | Timing word value |
| run | input | 1 | Clocking request from the byte engine |
| scl | output | 1 | SCL level to drive (1 = released high) |
| startStb | output | 1 | Start point; SDA may fall |
| sclFall | output | 1 | First cycle of a low phase |
| sclRise | output | 1 | First cycle of a high phase |
| sdaChg | output | 1 | SDA change point within the low phase |

## Verification
The SDA change point and the end of the low phase can land on the same clock. The bench provokes this by setting the SDA change field equal to the low step field. It then expects `sdaChg` and `sclRise` together in one cycle, and it counts how often that coincidence appears. The behavioural reference model tracks the two events on separate counters, an elapsed-tick count and a remaining-cycle count. A design that drops, delays or reorders either event disagrees with it on that exact cycle. A second setting pushes the change point past the end of the phase and expects no `sdaChg` at all.

// File: rtl/scl_phase_pkg.sv
package scl_phase_pkg;

  // Control-to-datapath strobes, all decoded from the phase state register.
  typedef struct packed {
    logic load;    // idle: copy shadow timing into active set
    logic setup;   // start-setup interval is running
    logic phase;   // an SCL phase (high or low) is running
    logic useLow;  // the running phase is the low phase
  } tgenCtl_t;

  // Datapath-to-control events.
  typedef struct packed {
    logic setupEnd;
    logic phaseEnd;
    logic sdaHit;
  } tgenEvt_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_HIGH  = 2'd2,
    ST_LOW   = 2'd3
  } tgenState_e;

endpackage

// File: rtl/scl_phase_regs.sv
module scl_phase_regs
  import scl_phase_pkg::*;
#(
  parameter int DIV_W  = 3,
  parameter int SMP_W  = 3,
  parameter int STP_W  = 6,
  parameter int SET_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  tgenCtl_t          ctl,
  output logic [SMP_W-1:0]  hiSmp,
  output logic [STP_W-1:0]  hiStp,
  output logic [SMP_W-1:0]  loSmp,
  output logic [STP_W-1:0]  loStp,
  output logic [SET_W-1:0]  setLim,
  output logic [DIV_W-1:0]  divLim,
  output logic              setupEn,
  output logic [STP_W-1:0]  sdaPt
);
  localparam int HI_SMP_LSB = 8;
  localparam int LO_SMP_LSB = 6;
  localparam int SET_LSB    = 8;
  localparam int DIV_LSB    = 1;
  localparam logic [1:0] A_HIGH = 2'd0;
  localparam logic [1:0] A_LOW  = 2'd1;
  localparam logic [1:0] A_EXT  = 2'd2;
  localparam logic [1:0] A_SDA  = 2'd3;

  logic [SMP_W-1:0] hiSmpS, loSmpS;
  logic [STP_W-1:0] hiStpS, loStpS, sdaPtS;
  logic [SET_W-1:0] setLimS;
  logic [DIV_W-1:0] divLimS;
  logic             setupEnS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiSmpS <= '0; hiStpS <= '0; loSmpS <= '0; loStpS <= '0;
      setLimS <= '0; divLimS <= '0; setupEnS <= 1'b0; sdaPtS <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        A_HIGH: begin
          hiSmpS <= wrData[HI_SMP_LSB +: SMP_W];
          hiStpS <= wrData[0 +: STP_W];
        end
        A_LOW: begin
          loSmpS <= wrData[LO_SMP_LSB +: SMP_W];
          loStpS <= wrData[0 +: STP_W];
        end
        A_EXT: begin
          setLimS  <= wrData[SET_LSB +: SET_W];
          divLimS  <= wrData[DIV_LSB +: DIV_W];
          setupEnS <= wrData[0];
        end
        A_SDA:   sdaPtS <= wrData[0 +: STP_W];
        default: ;
      endcase
    end
  end

  // Active set follows the shadow set only while idle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiSmp <= '0; hiStp <= '0; loSmp <= '0; loStp <= '0;
      setLim <= '0; divLim <= '0; setupEn <= 1'b0; sdaPt <= '0;
    end else if (ctl.load) begin
      hiSmp <= hiSmpS; hiStp <= hiStpS; loSmp <= loSmpS; loStp <= loStpS;
      setLim <= setLimS; divLim <= divLimS; setupEn <= setupEnS; sdaPt <= sdaPtS;
    end
  end

endmodule

// File: rtl/scl_phase_count.sv
module scl_phase_count
  import scl_phase_pkg::*;
#(
  parameter int DIV_W = 3,
  parameter int SMP_W = 3,
  parameter int STP_W = 6,
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tgenCtl_t         ctl,
  input  logic [SMP_W-1:0] hiSmp,
  input  logic [STP_W-1:0] hiStp,
  input  logic [SMP_W-1:0] loSmp,
  input  logic [STP_W-1:0] loStp,
  input  logic [SET_W-1:0] setLim,
  input  logic [DIV_W-1:0] divLim,
  input  logic [STP_W-1:0] sdaPt,
  output tgenEvt_t         evt
);
  logic [DIV_W-1:0] divQ;
  logic [SMP_W-1:0] smpQ, smpLim;
  logic [STP_W-1:0] stpQ, stpLim;
  logic [SET_W-1:0] setQ;
  logic             divEnd, smpEnd, restart;

  always_comb begin
    smpLim       = ctl.useLow ? loSmp : hiSmp;
    stpLim       = ctl.useLow ? loStp : hiStp;
    divEnd       = (divQ == divLim);
    smpEnd       = divEnd && (smpQ == smpLim);
    evt.phaseEnd = ctl.phase && smpEnd && (stpQ == stpLim);
    evt.sdaHit   = ctl.useLow && smpEnd && (stpQ == sdaPt);
    evt.setupEnd = ctl.setup && (setQ == setLim);
    restart      = !(ctl.setup || ctl.phase) || evt.setupEnd || evt.phaseEnd;
  end

  // All counters reload at every phase boundary and whenever idle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ <= '0; smpQ <= '0; stpQ <= '0; setQ <= '0;
    end else if (restart) begin
      divQ <= '0; smpQ <= '0; stpQ <= '0; setQ <= '0;
    end else if (ctl.setup) begin
      setQ <= setQ + 1'b1;
    end else if (divEnd) begin
      divQ <= '0;
      if (smpQ == smpLim) begin
        smpQ <= '0;
        stpQ <= stpQ + 1'b1;
      end else begin
        smpQ <= smpQ + 1'b1;
      end
    end else begin
      divQ <= divQ + 1'b1;
    end
  end

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_phase_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     run,
  input  logic     setupEn,
  input  tgenEvt_t evt,
  output tgenCtl_t ctl,
  output logic     scl,
  output logic     startStb,
  output logic     sclFall,
  output logic     sclRise,
  output logic     sdaChg
);
  tgenState_e state, nxt;

  always_comb begin
    ctl.load   = (state == ST_IDLE);
    ctl.setup  = (state == ST_SETUP);
    ctl.phase  = (state == ST_HIGH) || (state == ST_LOW);
    ctl.useLow = (state == ST_LOW);
    scl        = (state != ST_LOW);
    nxt        = state;
    case (state)
      ST_IDLE:  if (run) nxt = setupEn ? ST_SETUP : ST_HIGH;
      ST_SETUP: if (evt.setupEnd) nxt = ST_HIGH;
      ST_HIGH:  if (evt.phaseEnd) nxt = run ? ST_LOW : ST_IDLE;
      ST_LOW:   if (evt.phaseEnd) nxt = ST_HIGH;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      startStb <= 1'b0;
      sclFall  <= 1'b0;
      sclRise  <= 1'b0;
      sdaChg   <= 1'b0;
    end else begin
      state    <= nxt;
      startStb <= ((state == ST_SETUP) && evt.setupEnd) ||
                  ((state == ST_IDLE) && run && !setupEn);
      sclFall  <= (state == ST_HIGH) && evt.phaseEnd && run;
      sclRise  <= (state == ST_LOW) && evt.phaseEnd;
      sdaChg   <= evt.sdaHit;
    end
  end

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_phase_pkg::*;
#(
  parameter int DIV_W  = 3,
  parameter int SMP_W  = 3,
  parameter int STP_W  = 6,
  parameter int SET_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              run,
  output logic              scl,
  output logic              startStb,
  output logic              sclFall,
  output logic              sclRise,
  output logic              sdaChg
);
  localparam int CFG_W = 2 * SMP_W + 3 * STP_W + SET_W + DIV_W + 1;

  tgenCtl_t         ctlBus;
  tgenEvt_t         evtBus;
  logic [SMP_W-1:0] hiSmp, loSmp;
  logic [STP_W-1:0] hiStp, loStp, sdaPt;
  logic [SET_W-1:0] setLim;
  logic [DIV_W-1:0] divLim;
  logic             setupEn;
  logic [CFG_W-1:0] cfgAll;

  assign cfgAll = {hiSmp, hiStp, loSmp, loStp, setLim, divLim, setupEn, sdaPt};

  scl_phase_regs #(.DIV_W(DIV_W), .SMP_W(SMP_W), .STP_W(STP_W),
                   .SET_W(SET_W), .DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ctl(ctlBus), .hiSmp(hiSmp), .hiStp(hiStp), .loSmp(loSmp), .loStp(loStp),
    .setLim(setLim), .divLim(divLim), .setupEn(setupEn), .sdaPt(sdaPt)
  );

  scl_phase_count #(.DIV_W(DIV_W), .SMP_W(SMP_W), .STP_W(STP_W),
                    .SET_W(SET_W)) uCount (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .hiSmp(hiSmp), .hiStp(hiStp),
    .loSmp(loSmp), .loStp(loStp), .setLim(setLim), .divLim(divLim),
    .sdaPt(sdaPt), .evt(evtBus)
  );

  scl_phase_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .run(run), .setupEn(setupEn), .evt(evtBus),
    .ctl(ctlBus), .scl(scl), .startStb(startStb), .sclFall(sclFall),
    .sclRise(sclRise), .sdaChg(sdaChg)
  );

endmodule

// File: rtl/scl_phase_chk.sv
module scl_phase_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             scl,
  input logic             startStb,
  input logic             sclFall,
  input logic             sclRise,
  input logic             sdaChg,
  input logic             load,
  input logic [CFG_W-1:0] cfgAll
);
  // R7: a rise strobe marks the first high cycle after a low one
  a_r7_rise_edge: assert property (@(posedge clk) disable iff (!rstN)
    sclRise |-> (scl && !$past(scl)));

  // R7: a fall strobe marks the first low cycle after a high one
  a_r7_fall_edge: assert property (@(posedge clk) disable iff (!rstN)
    sclFall |-> (!scl && $past(scl)));

  // R7: start, fall and rise strobes are mutually exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startStb, sclFall, sclRise}));

  // R8: the SDA change point comes from inside a low phase
  a_r8_sda_in_low: assert property (@(posedge clk) disable iff (!rstN)
    sdaChg |-> !$past(scl));

  // R5: start point happens while SCL is high
  a_r5_start_high: assert property (@(posedge clk) disable iff (!rstN)
    startStb |-> scl);

  // R10: active timing changes only across an idle cycle
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !$past(load)) |-> $stable(cfgAll));

endmodule

bind scl_phase_gen scl_phase_chk #(.CFG_W(CFG_W)) uChk (
  .clk(clk), .rstN(rstN), .scl(scl), .startStb(startStb), .sclFall(sclFall),
  .sclRise(sclRise), .sdaChg(sdaChg), .load(ctlBus.load), .cfgAll(cfgAll)
);

// File: tb/sim_scl_phase_gen.sv
module sim_scl_phase_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic        run = 1'b0;
  logic        scl, startStb, sclFall, sclRise, sdaChg;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  always #2 clk = ~clk;

  scl_phase_gen u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .run(run), .scl(scl), .startStb(startStb), .sclFall(sclFall),
    .sclRise(sclRise), .sdaChg(sdaChg)
  );

  // ---------------- behavioural reference model ----------------
  int sHs, sHp, sLs, sLp, sU, sD, sEn, sH;   // shadow
  int aHs, aHp, aLs, aLp, aU, aD, aEn, aH;   // active
  int mode, rem, el;
  bit eStart, eFall, eRise, eSda;

  function automatic int hiLen();
    return (aD + 1) * (aHs + 1) * (aHp + 1);
  endfunction
  function automatic int loLen();
    return (aD + 1) * (aLs + 1) * (aLp + 1);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      {sHs, sHp, sLs, sLp, sU, sD, sEn, sH} = '{default: 0};
      {aHs, aHp, aLs, aLp, aU, aD, aEn, aH} = '{default: 0};
      mode = 0; rem = 0; el = 0;
      {eStart, eFall, eRise, eSda} = 4'b0;
    end else begin
      int enNow;
      {eStart, eFall, eRise, eSda} = 4'b0;
      case (mode)
        0: begin
          enNow = aEn;
          aHs = sHs; aHp = sHp; aLs = sLs; aLp = sLp;
          aU = sU; aD = sD; aEn = sEn; aH = sH;
          if (run) begin
            if (enNow != 0) begin mode = 1; rem = aU + 1; end
            else begin mode = 2; rem = hiLen(); eStart = 1; end
          end
        end
        1: begin
          rem--;
          if (rem == 0) begin mode = 2; rem = hiLen(); eStart = 1; end
        end
        2: begin
          rem--;
          if (rem == 0) begin
            if (run) begin mode = 3; rem = loLen(); el = 0; eFall = 1; end
            else mode = 0;
          end
        end
        default: begin
          rem--; el++;
          if (el == (aH + 1) * (aLs + 1) * (aD + 1)) eSda = 1;
          if (rem == 0) begin mode = 2; rem = hiLen(); eRise = 1; end
        end
      endcase
      if (wrEn) begin
        case (wrAddr)
          2'd0: begin sHs = (wrData >> 8) & 7; sHp = wrData & 63; end
          2'd1: begin sLs = (wrData >> 6) & 7; sLp = wrData & 63; end
          2'd2: begin sU = (wrData >> 8) & 255; sD = (wrData >> 1) & 7; sEn = wrData & 1; end
          default: sH = wrData & 63;
        endcase
      end
    end
  end

  // ---------------- per-cycle comparison and event monitor ----------------
  int prevFall = -1;
  int lastPeriod = 0;
  int coinCount = 0;
  int sdaCount = 0;
  int strobeCount = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      chk(scl == (mode != 3), "R3 scl level", scl, mode != 3);
      chk(startStb == eStart, "R5 startStb", startStb, eStart);
      chk(sclFall == eFall, "R7 sclFall", sclFall, eFall);
      chk(sclRise == eRise, "R7 sclRise", sclRise, eRise);
      chk(sdaChg == eSda, "R8 sdaChg", sdaChg, eSda);
      if (sclFall) begin
        if (prevFall >= 0) lastPeriod = cyc - prevFall;
        prevFall = cyc;
      end
      if (sdaChg && sclRise) coinCount++;
      if (sdaChg) sdaCount++;
      if (startStb || sclFall || sclRise || sdaChg) strobeCount++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setCfg(input int hs, hp, ls, lp, u, d, en, h);
    wr(2'd0, 16'((hs << 8) | hp));
    wr(2'd1, 16'((ls << 6) | lp));
    wr(2'd2, 16'((u << 8) | (d << 1) | en));
    wr(2'd3, 16'(h));
    repeat (2) @(negedge clk);
  endtask

  task automatic startRun();
    prevFall = -1; lastPeriod = 0;
    @(negedge clk);
    run = 1'b1;
  endtask

  task automatic stopRun();
    @(negedge clk);
    run = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired at cycle %0d actual=hung expected=done", cyc);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    int waitCnt;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(scl == 1'b1, "R1 reset scl", scl, 1);
    chk({startStb, sclFall, sclRise, sdaChg} == 4'b0, "R1 reset strobes",
        {startStb, sclFall, sclRise, sdaChg}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Config A: setup enabled, U=5; high 1*2*3=6, low 1*2*4=8 (R2, R3)
    setCfg(1, 2, 1, 3, 5, 0, 1, 1);
    startRun();
    waitCnt = 0;
    while (!startStb && waitCnt < 50) begin @(negedge clk); waitCnt++; end
    chk(waitCnt == 7, "R5 setup interval", waitCnt, 7);
    repeat (60) @(negedge clk);
    chk(lastPeriod == 14, "R4 period config A", lastPeriod, 14);

    // R10: rewrite to config B while running; period must not change
    setCfg(0, 1, 0, 2, 0, 2, 0, 2);
    repeat (40) @(negedge clk);
    chk(lastPeriod == 14, "R10 period kept during run", lastPeriod, 14);
    stopRun();
    // R9: idle, high, quiet
    strobeCount = 0;
    repeat (50) @(negedge clk);
    chk(scl == 1'b1, "R9 idle scl high", scl, 1);
    chk(strobeCount == 0, "R9 no strobes in idle", strobeCount, 0);

    // Config B now active: setup disabled (R6), H==low step (R8 coincidence)
    coinCount = 0;
    startRun();
    @(negedge clk);
    chk(startStb == 1'b1, "R6 immediate start", startStb, 1);
    repeat (80) @(negedge clk);
    chk(lastPeriod == 15, "R10 R4 new period after idle", lastPeriod, 15);
    chk(coinCount >= 3, "R8 sdaChg with sclRise", coinCount, 3);
    stopRun();

    // Config C: H beyond low phase -> no sdaChg; high 2*3*1=6, low 2*1*2=4
    setCfg(2, 0, 0, 1, 0, 1, 1, 3);
    sdaCount = 0;
    startRun();
    repeat (70) @(negedge clk);
    chk(lastPeriod == 10, "R3 period config C", lastPeriod, 10);
    chk(sdaCount == 0, "R8 no sdaChg past phase end", sdaCount, 0);
    stopRun();

    // Config D: early SDA point, larger divider, mid-low stop (R9)
    setCfg(3, 1, 2, 2, 20, 4, 1, 0);
    sdaCount = 0;
    startRun();
    repeat (200) @(negedge clk);
    chk(lastPeriod == 5 * 4 * 2 + 5 * 3 * 3, "R4 period config D", lastPeriod, 85);
    chk(sdaCount >= 1, "R8 sdaChg early point", sdaCount, 1);
    while (scl) @(negedge clk);
    run = 1'b0;
    repeat (120) @(negedge clk);
    chk(scl == 1'b1, "R9 stop after low phase", scl, 1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule